// File: doc/BRIEF.md
# Cache Line Straddle Splitter

This block sits in front of a cache tag directory and turns one memory reference, given as a byte address and a byte count, into the block probes the directory needs. It takes the first and last byte of the reference, reduces each to a line-sized block number, and decides whether the reference fits in one line, spans two neighbouring lines, or is illegal.

A reference inside one line produces one probe. A reference spanning two lines produces two probes, lower block first. The second probe is always sent, even when the first one has already missed, because every probe updates the directory's replacement state. Either way the reference counts as exactly one access. It is reported as a hit only when every probe hit. Any other outcome reports one miss. An illegal reference produces no probe and returns an error result.

The set index of each probe is the low bits of its block number. The block accepts one reference at a time. It stays busy from acceptance until its single-cycle result.

Top module: `line_split_top`

## Requirements
- R1: The first probe of every legal reference carries block number `addr >> log2(LINE_BYTES)`.
- R2: Every probe carries set index `block mod NUM_SETS`, which is the low `log2(NUM_SETS)` bits of its own block number.
- R3: When the last byte `addr + size - 1` lies in the same block as `addr`, exactly one probe is issued, and the result's miss flag is the inverse of that probe's hit response.
- R4: When the last byte lies in the block directly above the first, exactly two probes are issued. The first is for the lower block and the second is for the lower block plus one.
- R5: The second probe of a two-line reference is issued even when the first probe missed.
- R6: A two-line reference yields one result whose miss flag is 1 if either probe missed and 0 only if both hit.
- R7: A reference with size 0, with a last byte more than one block above the first, or with a last byte past the top of the address space, issues no probe. Its result appears in the first cycle after acceptance with the error flag at 1 and the miss flag at 0.
- R8: `res_valid` is high for exactly one cycle. That cycle is the one directly after the cycle in which the final probe response is presented.
- R9: `req_ready` is low from the cycle after acceptance through the result cycle. A request presented while `req_ready` is low is ignored and issues no probe.
- R10: During and directly after synchronous reset, including a reset in the middle of a split, `req_ready` is 1 and both `lk_req` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Reference presented |
| req_ready | output | 1 | Block idle, reference accepted this cycle if valid |
| req_addr | input | ADDR_W | Byte address of the reference |
| req_size | input | SIZE_W | Byte count of the reference |
| lk_req | output | 1 | Probe strobe to the tag directory, one cycle per probe |
| lk_block | output | ADDR_W-log2(LINE_BYTES) | Block number probed |
| lk_set | output | log2(NUM_SETS) | Set index probed |
| lk_rsp_valid | input | 1 | Directory response for the outstanding probe |
| lk_rsp_hit | input | 1 | Response says the block was present |
| res_valid | output | 1 | Result strobe, one cycle |
| res_miss | output | 1 | Reference counted as a miss |
| res_err | output | 1 | Reference was illegal |

## Verification
A legal reference drives its first probe in the cycle after acceptance. A second probe follows one cycle after the first response. The result comes one cycle after the last response, and an illegal reference reports its result in the first cycle after acceptance. The bench acts as the directory with a set response delay. It counts cycles from acceptance at falling edges and records the cycle in which it presented each response. It then requires the result exactly one cycle later, and requires it gone, with `req_ready` back high, in the cycle after that. A slower directory and a request pushed in while the block is busy check that the timing is set by the responses and not by a fixed count.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    typedef enum logic [1:0] {
        SPAN_ONE = 2'd0,
        SPAN_TWO = 2'd1,
        SPAN_BAD = 2'd2
    } span_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ1  = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_REQ2  = 3'd3,
        ST_WAIT2 = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/splitter_span.sv
module splitter_span
    import splitter_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 6,
    parameter int LINE_BITS = 4,
    localparam int BLK_W    = ADDR_W - LINE_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [BLK_W-1:0]  first_blk,
    output logic [BLK_W-1:0]  second_blk,
    output span_e             kind
);

    localparam logic [BLK_W:0]  ONE_BLK  = 1;
    localparam logic [ADDR_W:0] ONE_BYTE = 1;

    logic [ADDR_W:0] last_byte;
    logic [BLK_W:0]  first_w;
    logic [BLK_W:0]  last_w;
    logic [BLK_W:0]  next_w;

    always_comb begin
        last_byte = {1'b0, addr} + {{(ADDR_W+1-SIZE_W){1'b0}}, size} - ONE_BYTE;
        first_w   = {1'b0, addr[ADDR_W-1:LINE_BITS]};
        last_w    = last_byte[ADDR_W:LINE_BITS];
        next_w    = first_w + ONE_BLK;
        first_blk  = first_w[BLK_W-1:0];
        second_blk = next_w[BLK_W-1:0];
        if (size == '0 || last_byte[ADDR_W]) begin
            kind = SPAN_BAD;
        end else if (last_w == first_w) begin
            kind = SPAN_ONE;
        end else if (last_w == next_w) begin
            kind = SPAN_TWO;
        end else begin
            kind = SPAN_BAD;
        end
    end

endmodule

// File: rtl/splitter_merge.sv
module splitter_merge (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic hit,
    output logic miss_acc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            miss_acc <= 1'b0;
        end else if (upd && !hit) begin
            miss_acc <= 1'b1;
        end
    end

    // R6: a missing probe leaves the accumulated miss set
    a_r6_miss_sticks: assert property (@(posedge clk) disable iff (rst)
        (upd && !hit && !clr) |=> miss_acc);

    // R6: hits never raise the flag on their own
    a_r6_hit_no_raise: assert property (@(posedge clk) disable iff (rst)
        (!miss_acc && !(upd && !hit)) |=> !miss_acc);

endmodule

// File: rtl/splitter_seq.sv
module splitter_seq
    import splitter_pkg::*;
#(
    parameter int BLK_W    = 28,
    parameter int SET_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  span_e               kind_in,
    input  logic [BLK_W-1:0]    first_in,
    input  logic [BLK_W-1:0]    second_in,
    output logic                lk_req,
    output logic [BLK_W-1:0]    lk_block,
    output logic [SET_BITS-1:0] lk_set,
    input  logic                lk_rsp_valid,
    output logic                acc_clr,
    output logic                acc_upd,
    output logic                res_valid,
    output logic                res_err
);

    seq_state_e       state_q, state_d;
    logic [BLK_W-1:0] first_q, second_q;
    logic             two_q, err_q;
    logic             accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign lk_req    = (state_q == ST_REQ1) || (state_q == ST_REQ2);
    assign lk_block  = (state_q == ST_REQ2) ? second_q : first_q;
    assign lk_set    = lk_block[SET_BITS-1:0];
    assign acc_clr   = accept;
    assign acc_upd   = lk_rsp_valid && ((state_q == ST_WAIT1) || (state_q == ST_WAIT2));
    assign res_valid = (state_q == ST_DONE);
    assign res_err   = res_valid && err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (kind_in == SPAN_BAD) ? ST_DONE : ST_REQ1;
            ST_REQ1:  state_d = ST_WAIT1;
            ST_WAIT1: if (lk_rsp_valid) state_d = two_q ? ST_REQ2 : ST_DONE;
            ST_REQ2:  state_d = ST_WAIT2;
            ST_WAIT2: if (lk_rsp_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            first_q  <= '0;
            second_q <= '0;
            two_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                first_q  <= first_in;
                second_q <= second_in;
                two_q    <= (kind_in == SPAN_TWO);
                err_q    <= (kind_in == SPAN_BAD);
            end
        end
    end

    // R8: result strobe lasts one cycle
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R8: final response is followed by the result in the next cycle
    a_r8_after_rsp: assert property (@(posedge clk) disable iff (rst)
        (lk_rsp_valid && state_q == ST_WAIT2) |=> res_valid);

    // R9: busy right after acceptance
    a_r9_busy: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R4: second probe is the block after the first
    a_r4_order: assert property (@(posedge clk) disable iff (rst)
        (lk_req && state_q == ST_REQ2) |-> (lk_block == first_q + 1'b1));

    // R5: first response of a split always leads to a second probe
    a_r5_second: assert property (@(posedge clk) disable iff (rst)
        (lk_rsp_valid && state_q == ST_WAIT1 && two_q) |=> (lk_req && !res_valid));

    // R3: single-line reference finishes after its only response
    a_r3_single: assert property (@(posedge clk) disable iff (rst)
        (lk_rsp_valid && state_q == ST_WAIT1 && !two_q) |=> (res_valid && !lk_req));

    // R7: illegal reference skips the directory
    a_r7_no_probe: assert property (@(posedge clk) disable iff (rst)
        (accept && kind_in == SPAN_BAD) |=> (!lk_req && res_valid && res_err));

endmodule

// File: rtl/line_split_top.sv
module line_split_top
    import splitter_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 6,
    parameter int LINE_BYTES = 16,
    parameter int NUM_SETS   = 64,
    localparam int LINE_BITS = $clog2(LINE_BYTES),
    localparam int SET_BITS  = $clog2(NUM_SETS),
    localparam int BLK_W     = ADDR_W - LINE_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [SIZE_W-1:0]   req_size,
    output logic                lk_req,
    output logic [BLK_W-1:0]    lk_block,
    output logic [SET_BITS-1:0] lk_set,
    input  logic                lk_rsp_valid,
    input  logic                lk_rsp_hit,
    output logic                res_valid,
    output logic                res_miss,
    output logic                res_err
);

    span_e            kind;
    logic [BLK_W-1:0] first_blk, second_blk;
    logic             acc_clr, acc_upd, miss_acc;

    splitter_span #(
        .ADDR_W    (ADDR_W),
        .SIZE_W    (SIZE_W),
        .LINE_BITS (LINE_BITS)
    ) span_i (
        .addr       (req_addr),
        .size       (req_size),
        .first_blk  (first_blk),
        .second_blk (second_blk),
        .kind       (kind)
    );

    splitter_seq #(
        .BLK_W    (BLK_W),
        .SET_BITS (SET_BITS)
    ) seq_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .kind_in      (kind),
        .first_in     (first_blk),
        .second_in    (second_blk),
        .lk_req       (lk_req),
        .lk_block     (lk_block),
        .lk_set       (lk_set),
        .lk_rsp_valid (lk_rsp_valid),
        .acc_clr      (acc_clr),
        .acc_upd      (acc_upd),
        .res_valid    (res_valid),
        .res_err      (res_err)
    );

    splitter_merge merge_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (acc_clr),
        .upd      (acc_upd),
        .hit      (lk_rsp_hit),
        .miss_acc (miss_acc)
    );

    assign res_miss = res_valid && !res_err && miss_acc;

    // R7: an error result never reports a miss
    a_r7_err_no_miss: assert property (@(posedge clk) disable iff (rst)
        res_err |-> (res_valid && !res_miss));

    // R9: no probe while the block is idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !lk_req);

endmodule

// File: tb/line_split_top_tb_top.sv
module line_split_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [5:0]  req_size;
    logic        lk_req;
    logic [27:0] lk_block;
    logic [5:0]  lk_set;
    logic        lk_rsp_valid;
    logic        lk_rsp_hit;
    logic        res_valid;
    logic        res_miss;
    logic        res_err;

    always #2 clk = ~clk;

    line_split_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .lk_req(lk_req),
        .lk_block(lk_block), .lk_set(lk_set), .lk_rsp_valid(lk_rsp_valid),
        .lk_rsp_hit(lk_rsp_hit), .res_valid(res_valid), .res_miss(res_miss),
        .res_err(res_err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [5:0]  size;
        logic        h1;
        logic        h2;
        logic [1:0]  nlook;
        logic [27:0] b1;
        logic [27:0] b2;
        logic        miss;
        logic        err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 6'd4,  1'b1, 1'b0, 2'd1, 28'h10,      28'h0,  1'b0, 1'b0},
        '{32'h0000_010C, 6'd4,  1'b0, 1'b0, 2'd1, 28'h10,      28'h0,  1'b1, 1'b0},
        '{32'h0000_010E, 6'd4,  1'b1, 1'b1, 2'd2, 28'h10,      28'h11, 1'b0, 1'b0},
        '{32'h0000_01FC, 6'd8,  1'b0, 1'b1, 2'd2, 28'h1F,      28'h20, 1'b1, 1'b0},
        '{32'h0000_03F8, 6'd16, 1'b1, 1'b0, 2'd2, 28'h3F,      28'h40, 1'b1, 1'b0},
        '{32'h0000_2001, 6'd31, 1'b0, 1'b0, 2'd2, 28'h200,     28'h201,1'b1, 1'b0},
        '{32'h0000_0500, 6'd16, 1'b1, 1'b0, 2'd1, 28'h50,      28'h0,  1'b0, 1'b0},
        '{32'h0000_0500, 6'd33, 1'b0, 1'b0, 2'd0, 28'h0,       28'h0,  1'b0, 1'b1},
        '{32'h0000_0040, 6'd0,  1'b0, 1'b0, 2'd0, 28'h0,       28'h0,  1'b0, 1'b1},
        '{32'hFFFF_FFF8, 6'd16, 1'b0, 1'b0, 2'd0, 28'h0,       28'h0,  1'b0, 1'b1},
        '{32'hFFFF_FFF0, 6'd16, 1'b1, 1'b0, 2'd1, 28'hFFFFFFF, 28'h0,  1'b0, 1'b0},
        '{32'h0000_030F, 6'd1,  1'b0, 1'b0, 2'd1, 28'h30,      28'h0,  1'b1, 1'b0},
        '{32'h0000_07F1, 6'd47, 1'b0, 1'b0, 2'd0, 28'h0,       28'h0,  1'b0, 1'b1},
        '{32'h0000_07F0, 6'd32, 1'b1, 1'b1, 2'd2, 28'h7F,      28'h80, 1'b0, 1'b0}
    };

    int applied = 0;
    int fails   = 0;

    int          got_n;
    logic [27:0] got_b [2];
    logic [5:0]  got_s [2];
    logic        got_miss, got_err;
    int          rsp_at, res_at;
    logic        pulse_after, ready_after, lk_after, busy_seen;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        applied++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    endtask

    task automatic run_ref(input logic [31:0] a, input logic [5:0] sz, input logic h1,
                           input logic h2, input int lat, input bit intrude);
        int cnt;
        req_valid = 1'b1; req_addr = a; req_size = sz;
        @(negedge clk);
        got_n = 0; cnt = 0; rsp_at = -1; res_at = -1; busy_seen = 1'b1;
        got_miss = 1'bx; got_err = 1'bx;
        for (int c = 0; c < 40; c++) begin
            lk_rsp_valid = 1'b0;
            req_valid    = 1'b0;
            if (res_valid) begin
                res_at = c; got_miss = res_miss; got_err = res_err;
                break;
            end
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    lk_rsp_valid = 1'b1;
                    lk_rsp_hit   = (got_n == 1) ? h1 : h2;
                    rsp_at       = c;
                end
            end
            if (lk_req) begin
                if (got_n < 2) begin
                    got_b[got_n] = lk_block;
                    got_s[got_n] = lk_set;
                end
                got_n++;
                cnt = lat;
            end
            if (intrude && c == 0) begin
                req_valid = 1'b1; req_addr = 32'h0000_ABC0; req_size = 6'd4;
                busy_seen = req_ready;
            end
            @(negedge clk);
        end
        lk_rsp_valid = 1'b0;
        req_valid    = 1'b0;
        @(negedge clk);
        pulse_after = res_valid;
        ready_after = req_ready;
        lk_after    = lk_req;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
        lk_rsp_valid = 1'b0; lk_rsp_hit = 1'b0;
        repeat (3) @(negedge clk);
        // R10: state held in reset
        chk(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
        chk(lk_req == 1'b0, "R10 no probe in reset", 64'(lk_req), 64'd0);
        chk(res_valid == 1'b0, "R10 no result in reset", 64'(res_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            run_ref(v.addr, v.size, v.h1, v.h2, 1, 1'b0);
            chk(got_err == v.err, "R7 error flag", 64'(got_err), 64'(v.err));
            chk(got_n == int'(v.nlook), v.err ? "R7 probe count" : (v.nlook == 2 ? "R4 probe count" : "R3 probe count"),
                64'(got_n), 64'(v.nlook));
            chk(got_miss == v.miss, v.nlook == 2 ? "R6 merged miss" : "R3 miss flag",
                64'(got_miss), 64'(v.miss));
            if (v.nlook >= 1) begin
                chk(got_b[0] == v.b1, "R1 first block", 64'(got_b[0]), 64'(v.b1));
                chk(got_s[0] == v.b1[5:0], "R2 first set", 64'(got_s[0]), 64'(v.b1[5:0]));
                chk(res_at == rsp_at + 1, "R8 result timing", 64'(res_at), 64'(rsp_at + 1));
            end else begin
                chk(res_at == 0, "R7 result timing", 64'(res_at), 64'd0);
            end
            if (v.nlook == 2) begin
                chk(got_b[1] == v.b2, v.h1 ? "R4 second block" : "R5 second block after miss",
                    64'(got_b[1]), 64'(v.b2));
                chk(got_s[1] == v.b2[5:0], "R2 second set", 64'(got_s[1]), 64'(v.b2[5:0]));
            end
            chk(pulse_after == 1'b0, "R8 single pulse", 64'(pulse_after), 64'd0);
            chk(ready_after == 1'b1, "R9 ready after result", 64'(ready_after), 64'd1);
            chk(lk_after == 1'b0, "R9 quiet after result", 64'(lk_after), 64'd0);
        end

        // R9/R8: slow directory and a request pushed in while busy
        run_ref(32'h0000_03F8, 6'd16, 1'b0, 1'b0, 3, 1'b1);
        chk(busy_seen == 1'b0, "R9 busy during split", 64'(busy_seen), 64'd0);
        chk(got_n == 2, "R9 intruding request ignored", 64'(got_n), 64'd2);
        chk(got_b[0] == 28'h3F, "R4 slow first block", 64'(got_b[0]), 64'h3F);
        chk(got_b[1] == 28'h40, "R5 slow second block", 64'(got_b[1]), 64'h40);
        chk(got_miss == 1'b1, "R6 both missed one miss", 64'(got_miss), 64'd1);
        chk(res_at == rsp_at + 1, "R8 slow result timing", 64'(res_at), 64'(rsp_at + 1));
        chk(lk_after == 1'b0, "R9 no probe for ignored request", 64'(lk_after), 64'd0);

        // R10: reset in the middle of a split
        req_valid = 1'b1; req_addr = 32'h0000_010E; req_size = 6'd4;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, "R10 ready after mid reset", 64'(req_ready), 64'd1);
        chk(lk_req == 1'b0, "R10 no probe after mid reset", 64'(lk_req), 64'd0);
        chk(res_valid == 1'b0, "R10 no result after mid reset", 64'(res_valid), 64'd0);
        @(negedge clk);
        run_ref(32'h0000_0100, 6'd4, 1'b1, 1'b0, 1, 1'b0);
        chk(got_n == 1, "R10 clean run after reset", 64'(got_n), 64'd1);
        chk(got_miss == 1'b0, "R3 hit after reset", 64'(got_miss), 64'd0);

        finish_run();
    end

endmodule